// File: doc/BRIEF.md
# IO Virtual Address Translator

This block converts the addresses that I/O devices present for DMA into physical memory addresses. The mapping lives in a single-level page directory in system memory. Each 4 KiB page of the I/O virtual space has one 64-bit entry there. A small fully associative translation cache sits in front of the directory, so that repeated accesses to a page do not go back to memory.

Software configures three things through a small register port: a window base, a window mask and the directory base. The window base also carries the translation enable in bit 0. Software can also purge cached translations, either by address range or all at once.

A device presents one address at a time on the request port. The block answers with a physical address, a coherence index, or a fault. A controller state machine has three states:
- `S_IDLE`: accepts a request. Transition *idle-to-issue* is taken on a cache miss inside an enabled window. Every other accepted request answers directly and stays in `S_IDLE`.
- `S_ISSUE`: drives one memory read. Transition *issue-to-wait* is unconditional.
- `S_WAIT`: waits for the read data. Transition *wait-to-idle* is taken when the data arrives.

Top module: `iova_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_valid` are 0. The cache holds no entries, so the first translated request always reads memory.
- R2: While bit 0 of the window base register (`cfg_sel`=0) is 0, an accepted request is answered on the next cycle with no fault. `rsp_addr` equals the request address zero-extended to 40 bits, and no memory read is issued.
- R3: While translation is enabled, a request whose address ANDed with the mask register (`cfg_sel`=1) differs from the base (bit 0 cleared) ANDed with the mask is answered on the next cycle with `rsp_fault`=1 and `rsp_addr`=0. No memory read is issued.
- R4: On a cache miss inside the window, `mem_rd_valid` is high for exactly one cycle, the cycle after acceptance. `mem_rd_addr` = directory base (`cfg_sel`=2) + (request address >> 12) * 8.
- R5: When the read data arrives with bit 63 set, the response follows one cycle later. `rsp_fault`=0, `rsp_addr` = {data[39:12], request[11:0]} and `rsp_ci` = data[7:0]. The entry is cached.
- R6: Read data with bit 63 clear gives `rsp_fault`=1 and is not cached. A repeated request to that page reads memory again.
- R7: A request that hits the cache is answered on the cycle after acceptance with the cached page and the request's low 12 bits. No memory read is issued.
- R8: The cache holds 8 entries and replaces them round-robin. After 9 distinct pages are installed, the first page misses and the second still hits.
- R9: A write to the purge register (`cfg_sel`=3) with log2 size L in bits 4:0 (L below 12 treated as 12) and an address in bits 31:12 invalidates every cached page that equals that address in page bits at or above L. Other entries stay.
- R10: A purge with L=31 invalidates every cached entry.
- R11: A purge that arrives while a fetch is outstanding and covers the fetched page still lets the response be returned, but the entry is not cached. A non-covering purge does not stop the install.
- R12: `req_ready` is 0 from acceptance of a miss until its response. A request presented in that time is ignored: it gives no response and no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 window base, 1 window mask, 2 directory base, 3 purge |
| cfg_wdata | input | 40 | Register write data |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 32 | I/O virtual address |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 1 | Translation failed |
| rsp_addr | output | 40 | Physical address |
| rsp_ci | output | 8 | Coherence index of the page |
| mem_rd_valid | output | 1 | Directory read request, one cycle |
| mem_rd_addr | output | 40 | Directory entry address |
| mem_rd_data_valid | input | 1 | Directory read data present |
| mem_rd_data | input | 64 | Directory entry |

## Verification
Pass-through, window faults and cache hits are due on the cycle after the accepting edge. A miss drives `mem_rd_valid` on that same following cycle, and its response is due one cycle after the edge that captures the read data.

The bench drives every input at a falling edge and samples all outputs at the next falling edge. Each check therefore lands exactly in the cycle where its result is due, with no slack that could hide a late or early answer.

Cache state (replacement, purges, cancelled installs) is observed only through whether a later request answers immediately or issues a memory read.

// File: rtl/iova_pkg.sv
package iova_pkg;
    localparam int IOVA_W     = 32;
    localparam int PA_W       = 40;
    localparam int PAGE_SHIFT = 12;
    localparam int CI_W       = 8;
    localparam int TAG_W      = IOVA_W - PAGE_SHIFT;
    localparam int PPN_W      = PA_W - PAGE_SHIFT;
    localparam int ENT_W      = 64;
    localparam int VALID_BIT  = ENT_W - 1;
    localparam logic [4:0] PURGE_ALL_LG = 5'd31;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT
    } walk_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
        logic [CI_W-1:0]  ci;
    } tc_entry_t;

    // Page-number bits that must match for a purge of size 2**lg.
    function automatic logic [TAG_W-1:0] purge_mask(input logic [4:0] lg);
        logic [TAG_W-1:0] m;
        for (int i = 0; i < TAG_W; i++) begin
            m[i] = (lg != PURGE_ALL_LG) && ((i + PAGE_SHIFT) >= int'(lg));
        end
        return m;
    endfunction
endpackage

// File: rtl/iova_tcache.sv
module iova_tcache
    import iova_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [CI_W-1:0]  lk_ci,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic [CI_W-1:0]  wr_ci,
    input  logic             pg_en,
    input  logic [TAG_W-1:0] pg_tag,
    input  logic [4:0]       pg_lg
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tc_entry_t          ent_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [ENTRIES-1:0] pg_vec;
    logic [IDX_W-1:0]   ptr_q;
    logic [TAG_W-1:0]   pmask;

    assign pmask = purge_mask(pg_lg);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign hit_vec[g] = vld_q[g] && (ent_q[g].tag == lk_tag);
        assign pg_vec[g]  = vld_q[g] && (((ent_q[g].tag ^ pg_tag) & pmask) == '0);
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_ci  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_hit = 1'b1;
                lk_ppn = lk_ppn | ent_q[i].ppn;
                lk_ci  = lk_ci | ent_q[i].ci;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            if (pg_en) begin
                vld_q <= vld_q & ~pg_vec;
            end
            if (wr_en) begin
                vld_q[ptr_q] <= 1'b1;
                ent_q[ptr_q] <= '{tag: wr_tag, ppn: wr_ppn, ci: wr_ci};
                ptr_q        <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7
    AST_PURGE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_en && pg_lg == PURGE_ALL_LG && !wr_en) |=> (vld_q == '0)); // R10
endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iova_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IOVA_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [CI_W-1:0]   rsp_ci,
    input  logic [IOVA_W-1:0] win_base,
    input  logic [IOVA_W-1:0] win_mask,
    input  logic [PA_W-1:0]   dir_base,
    output logic              mem_rd_valid,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_data_valid,
    input  logic [ENT_W-1:0]  mem_rd_data,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_hit,
    input  logic [PPN_W-1:0]  lk_ppn,
    input  logic [CI_W-1:0]   lk_ci,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [PPN_W-1:0]  wr_ppn,
    output logic [CI_W-1:0]   wr_ci,
    input  logic              pg_en,
    input  logic [TAG_W-1:0]  pg_tag,
    input  logic [4:0]        pg_lg
);
    walk_state_e       state_q, state_d;
    logic [IOVA_W-1:0] addr_q;
    logic              kill_q;
    logic              xl_en, in_win, accept, need_fetch, pg_match, data_ok;
    logic              unused_bits;

    assign unused_bits = ^{mem_rd_data[ENT_W-2:PA_W], mem_rd_data[PAGE_SHIFT-1:CI_W]};

    assign xl_en      = win_base[0];
    assign in_win     = ((req_addr & win_mask) == ({win_base[IOVA_W-1:1], 1'b0} & win_mask));
    assign lk_tag     = req_addr[IOVA_W-1:PAGE_SHIFT];
    assign accept     = (state_q == S_IDLE) && req_valid;
    assign need_fetch = xl_en && in_win && !lk_hit;
    assign pg_match   = pg_en && (((pg_tag ^ addr_q[IOVA_W-1:PAGE_SHIFT]) & purge_mask(pg_lg)) == '0);
    assign data_ok    = mem_rd_data[VALID_BIT];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept && need_fetch) state_d = S_ISSUE;
            S_ISSUE: state_d = S_WAIT;
            S_WAIT:  if (mem_rd_data_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request capture, purge kill flag and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            kill_q    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_addr  <= '0;
            rsp_ci    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                addr_q <= req_addr;
                kill_q <= 1'b0;
                if (!need_fetch) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= xl_en && !in_win;
                    if (!xl_en) begin
                        rsp_addr <= {{(PA_W-IOVA_W){1'b0}}, req_addr};
                        rsp_ci   <= '0;
                    end else if (!in_win) begin
                        rsp_addr <= '0;
                        rsp_ci   <= '0;
                    end else begin
                        rsp_addr <= {lk_ppn, req_addr[PAGE_SHIFT-1:0]};
                        rsp_ci   <= lk_ci;
                    end
                end
            end else if (state_q != S_IDLE && pg_match) begin
                kill_q <= 1'b1;
            end
            if (state_q == S_WAIT && mem_rd_data_valid) begin
                rsp_valid <= 1'b1;
                rsp_fault <= !data_ok;
                rsp_addr  <= data_ok ? {mem_rd_data[PA_W-1:PAGE_SHIFT], addr_q[PAGE_SHIFT-1:0]} : '0;
                rsp_ci    <= data_ok ? mem_rd_data[CI_W-1:0] : '0;
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        mem_rd_valid = (state_q == S_ISSUE);
        mem_rd_addr  = dir_base + {{(PA_W-IOVA_W-3+PAGE_SHIFT){1'b0}}, addr_q[IOVA_W-1:PAGE_SHIFT], 3'b000};
        wr_en        = (state_q == S_WAIT) && mem_rd_data_valid && data_ok && !kill_q && !pg_match;
        wr_tag       = addr_q[IOVA_W-1:PAGE_SHIFT];
        wr_ppn       = mem_rd_data[PA_W-1:PAGE_SHIFT];
        wr_ci        = mem_rd_data[CI_W-1:0];
    end

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid); // R4
    AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && xl_en && in_win && lk_hit) |=> rsp_valid); // R7
    AST_INSTALL_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rsp_valid && !rsp_fault)); // R5
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !rsp_valid); // R12
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
    import iova_pkg::*;
#(
    parameter int TC_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PA_W-1:0]   cfg_wdata,
    input  logic              req_valid,
    input  logic [IOVA_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_addr,
    output logic [CI_W-1:0]   rsp_ci,
    output logic              mem_rd_valid,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_data_valid,
    input  logic [ENT_W-1:0]  mem_rd_data
);
    logic [IOVA_W-1:0] win_base_q, win_mask_q;
    logic [PA_W-1:0]   dir_base_q;
    logic              pg_en, lk_hit, wr_en;
    logic [TAG_W-1:0]  lk_tag, wr_tag, pg_tag;
    logic [PPN_W-1:0]  lk_ppn, wr_ppn;
    logic [CI_W-1:0]   lk_ci, wr_ci;
    logic [4:0]        pg_lg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base_q <= '0;
            win_mask_q <= '0;
            dir_base_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                2'd0:    win_base_q <= cfg_wdata[IOVA_W-1:0];
                2'd1:    win_mask_q <= cfg_wdata[IOVA_W-1:0];
                2'd2:    dir_base_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    assign pg_en  = cfg_we && (cfg_sel == 2'd3);
    assign pg_tag = cfg_wdata[IOVA_W-1:PAGE_SHIFT];
    assign pg_lg  = cfg_wdata[4:0];

    iova_walker u_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_ci(rsp_ci),
        .win_base(win_base_q), .win_mask(win_mask_q), .dir_base(dir_base_q),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data),
        .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ci(lk_ci),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_ppn(wr_ppn), .wr_ci(wr_ci),
        .pg_en(pg_en), .pg_tag(pg_tag), .pg_lg(pg_lg)
    );

    iova_tcache #(.ENTRIES(TC_ENTRIES)) u_tcache (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_ci(lk_ci),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_ppn(wr_ppn), .wr_ci(wr_ci),
        .pg_en(pg_en), .pg_tag(pg_tag), .pg_lg(pg_lg)
    );
endmodule

// File: tb/iova_xlate_test.sv
module iova_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [39:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, rsp_valid, rsp_fault, mem_rd_valid;
    logic [39:0] rsp_addr, mem_rd_addr;
    logic [7:0]  rsp_ci;
    logic        mem_rd_data_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;

    int vecs = 0;
    int errs = 0;
    localparam logic [39:0] DIR = 40'h00_8000_0000;

    always #10 clk = ~clk;

    iova_xlate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr), .rsp_ci(rsp_ci),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data_valid(mem_rd_data_valid), .mem_rd_data(mem_rd_data)
    );

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [27:0] ppn, input logic [7:0] ci);
        return {1'b1, 23'b0, ppn, 4'b0, ci};
    endfunction

    task automatic cfg_wr(input logic [1:0] sel, input logic [39:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // request answered without memory: pass-through, window fault or cache hit
    task automatic xl_direct(input logic [31:0] a, input bit ef, input logic [39:0] ea, input string rq);
        issue(a);
        check(rsp_valid == 1'b1, {rq, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_fault == ef, {rq, " rsp_fault"}, 64'(rsp_fault), 64'(ef));
        check(rsp_addr == ea, {rq, " rsp_addr"}, 64'(rsp_addr), 64'(ea));
        check(mem_rd_valid == 1'b0, {rq, " no read"}, 64'(mem_rd_valid), 64'd0);
    endtask

    // request that must fetch its directory entry
    task automatic xl_miss(input logic [31:0] a, input logic [63:0] d, input bit pg,
                           input logic [39:0] pgw, input bit spur, input string rq);
        logic [39:0] ea;
        logic        ef;
        issue(a);
        check(rsp_valid == 1'b0, {rq, " R4 no early rsp"}, 64'(rsp_valid), 64'd0);
        check(mem_rd_valid == 1'b1, {rq, " R4 read issued"}, 64'(mem_rd_valid), 64'd1);
        check(mem_rd_addr == DIR + {5'b0, a[31:12], 3'b0}, {rq, " R4 read addr"},
              64'(mem_rd_addr), 64'(DIR + {5'b0, a[31:12], 3'b0}));
        if (pg) begin
            cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = pgw;
        end
        if (spur) begin
            check(req_ready == 1'b0, "R12 busy", 64'(req_ready), 64'd0);
            req_valid = 1'b1; req_addr = a ^ 32'h0000_1000;
        end
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check(mem_rd_valid == 1'b0, {rq, " R4 single pulse"}, 64'(mem_rd_valid), 64'd0);
        mem_rd_data_valid = 1'b1; mem_rd_data = d;
        @(negedge clk);
        mem_rd_data_valid = 1'b0;
        ef = !d[63];
        ea = ef ? 40'h0 : {d[39:12], a[11:0]};
        check(rsp_valid == 1'b1, {rq, " R5 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_fault == ef, {rq, " R5/R6 rsp_fault"}, 64'(rsp_fault), 64'(ef));
        check(rsp_addr == ea, {rq, " R5 rsp_addr"}, 64'(rsp_addr), 64'(ea));
        if (!ef) check(rsp_ci == d[7:0], {rq, " R5 rsp_ci"}, 64'(rsp_ci), 64'(d[7:0]));
        if (spur) begin
            @(negedge clk);
            check(rsp_valid == 1'b0, "R12 ignored rsp", 64'(rsp_valid), 64'd0);
            check(mem_rd_valid == 1'b0, "R12 ignored read", 64'(mem_rd_valid), 64'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_rd_valid == 1'b0, "R1 mem_rd_valid", 64'(mem_rd_valid), 64'd0);

        // R2 pass-through while disabled
        xl_direct(32'h1234_5678, 1'b0, 40'h00_1234_5678, "R2");
        xl_direct(32'hFFFF_F001, 1'b0, 40'h00_FFFF_F001, "R2");

        cfg_wr(2'd1, 40'h00_F000_0000);
        cfg_wr(2'd2, DIR);
        cfg_wr(2'd0, 40'h00_4000_0001);

        // R3 outside the window
        xl_direct(32'h5000_0000, 1'b1, 40'h0, "R3");
        xl_direct(32'h3FFF_FFFC, 1'b1, 40'h0, "R3");

        // R1 first translated request misses; R4/R5 fetch, R7 hit
        xl_miss(32'h4000_3ABC, mk(28'hABC_DE12, 8'h55), 1'b0, '0, 1'b0, "R1 R5");
        xl_direct(32'h4000_3010, 1'b0, 40'hAB_CDE1_2010, "R7");
        check(rsp_ci == 8'h55, "R7 ci", 64'(rsp_ci), 64'h55);

        // R6 invalid entry faults and is not cached
        xl_miss(32'h4000_7123, 64'h0000_0011_1111_1000, 1'b0, '0, 1'b0, "R6");
        xl_miss(32'h4000_7123, 64'h0000_0011_1111_1000, 1'b0, '0, 1'b0, "R6 refetch");

        // R10 purge all
        cfg_wr(2'd3, 40'd31);
        xl_miss(32'h4000_3ABC, mk(28'hABC_DE12, 8'h55), 1'b0, '0, 1'b0, "R10");

        // R8 round-robin capacity
        cfg_wr(2'd3, 40'd31);
        for (int p = 0; p < 9; p++) begin
            xl_miss(32'h4001_0000 + 32'(p << 12), mk(28'h100 + 28'(p), 8'(p)), 1'b0, '0, 1'b0, "R8 fill");
        end
        xl_direct(32'h4001_1004, 1'b0, {28'h101, 12'h004}, "R8 survivor");
        xl_miss(32'h4001_0008, mk(28'h100, 8'h0), 1'b0, '0, 1'b0, "R8 evicted");

        // R9 purge by address
        cfg_wr(2'd3, 40'd31);
        xl_miss(32'h4002_0000, mk(28'h200, 8'h1), 1'b0, '0, 1'b0, "R9 fill");
        xl_miss(32'h4002_1000, mk(28'h201, 8'h2), 1'b0, '0, 1'b0, "R9 fill");
        cfg_wr(2'd3, 40'h00_4002_000C);
        xl_direct(32'h4002_1010, 1'b0, {28'h201, 12'h010}, "R9 kept");
        xl_miss(32'h4002_0010, mk(28'h200, 8'h1), 1'b0, '0, 1'b0, "R9 purged");
        cfg_wr(2'd3, 40'h00_4002_1003);
        xl_miss(32'h4002_1020, mk(28'h201, 8'h2), 1'b0, '0, 1'b0, "R9 small lg");
        xl_miss(32'h4002_2000, mk(28'h202, 8'h3), 1'b0, '0, 1'b0, "R9 fill");
        xl_miss(32'h4002_3000, mk(28'h203, 8'h4), 1'b0, '0, 1'b0, "R9 fill");
        xl_miss(32'h4002_4000, mk(28'h204, 8'h5), 1'b0, '0, 1'b0, "R9 fill");
        cfg_wr(2'd3, 40'h00_4002_200D);
        xl_direct(32'h4002_4030, 1'b0, {28'h204, 12'h030}, "R9 outside 8K");
        xl_miss(32'h4002_2030, mk(28'h202, 8'h3), 1'b0, '0, 1'b0, "R9 8K lo");
        xl_miss(32'h4002_3030, mk(28'h203, 8'h4), 1'b0, '0, 1'b0, "R9 8K hi");

        // R11 purge while fetch outstanding; R12 busy
        cfg_wr(2'd3, 40'd31);
        xl_miss(32'h4003_0ABC, mk(28'h300, 8'h7), 1'b1, 40'h00_4003_000C, 1'b1, "R11 killed");
        xl_miss(32'h4003_0ABC, mk(28'h300, 8'h7), 1'b0, '0, 1'b0, "R11 not cached");
        xl_miss(32'h4003_1000, mk(28'h301, 8'h8), 1'b1, 40'h00_4003_200C, 1'b0, "R11 other purge");
        xl_direct(32'h4003_1FFF, 1'b0, {28'h301, 12'hFFF}, "R11 installed");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule